// File: doc/BRIEF.md
# Serial flash command front-end

This block is the slave-side decoder of a serial flash read port. A host frames every instruction by pulling chip select low. On rising SCK it shifts in an 8-bit opcode, then a 24-bit location, then 32 don't-care clocks. After that the block streams array bytes on SO for as long as the host keeps clocking. No further address is needed: an internal counter walks through the 528 columns of a page and then on to the next of 8192 pages, wrapping back to page 0 after the last one.

The bits shifted in are recognised only when CS, SCK and SI are sampled by the block's own clock through a short synchroniser. The array itself is outside the block. It is reached through a synchronous read port: a one-cycle request with page and column, and the byte returned on the following cycle. Two read opcodes select how SO is clocked. The edge-follower opcode (0x68) moves SO on falling SCK, which suits hosts in SPI mode 0 or 3. The level-follower opcode (0xE8) moves SO on rising SCK, which suits hosts whose SCK rests low or high between frames and that sample on the falling edge. Any other opcode makes the block sit out the rest of the frame.

The controller is a state machine with six states. IDLE holds while CS is high. OPCODE collects 8 bits. From OPCODE the machine goes to ADDR on a read opcode, or to IGNORE on any other opcode. ADDR collects 24 bits and then goes to DUMMY. DUMMY counts 32 clocks and then goes to STREAM. STREAM drives data until the frame ends. From every state, CS going high returns the machine to IDLE.

Top module: `sflash_cmd_frontend`

## Requirements
- R1: While CS is high the block is in IDLE. SO_OE is low no later than SYNC_STAGES+1 clock cycles after CS rises, and SCK or SI activity while CS is high has no effect on a later frame.
- R2: The first 8 bits sampled on rising SCK after CS falls form the opcode, most significant bit first.
- R3: Opcode 0x68 selects the edge-follower read and opcode 0xE8 selects the level-follower read. Any other opcode leaves SO_OE low and issues no memory read for the rest of that frame.
- R4: The next 24 rising-edge bits, most significant bit first, are one ignored bit, then a 13-bit page, then a 10-bit column. The first byte read comes from that page and column.
- R5: SO_OE stays low through the opcode, the address and the 32 don't-care clocks.
- R6: In the edge-follower read, the most significant bit of the first byte appears on SO after the falling SCK that follows the 64th rising SCK. Each later falling SCK presents the next bit.
- R7: In the level-follower read, the most significant bit of the first byte appears on SO after the 64th rising SCK. Each later rising SCK presents the next bit.
- R8: Bytes leave most significant bit first, and consecutive bytes come from consecutive array locations with no further host input.
- R9: After column 527, or any column above it, the column returns to 0 and the page advances by one.
- R10: After page 8191 the page returns to 0.
- R11: Raising CS in the middle of a stream stops it and turns SO_OE off. The next frame decodes normally.
- R12: Each memory read is a single-cycle MEM_RD_EN pulse with MEM_PAGE and MEM_COL valid, and MEM_RDATA is taken on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, frames an instruction |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | High when SO must be driven; low means high impedance |
| mem_rd_en | output | 1 | Single-cycle array read request |
| mem_page | output | 13 | Page of the read request |
| mem_col | output | 10 | Column of the read request |
| mem_rdata | input | 8 | Array byte, valid the cycle after the request |

## Verification
The checks assume that each SCK level, and the CS setup before the first rising SCK, last long enough for the synchronised copies to show every edge. That means at least SYNC_STAGES+2 block clocks per phase. They also assume the array answers exactly one cycle after each request. The bench holds every SCK phase for six block clocks and changes SI only while SCK is low. It keeps CS low for several clocks before the first edge and after the last one. Its behavioural array answers each request on the next edge. Random frames mix both read opcodes, both SCK rest levels, columns and pages close to their wrap points, unknown opcodes and streams cut short by CS. All of these stay inside those timing limits.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_STREAM,
        ST_IGNORE
    } sfc_state_e;

    typedef enum logic {
        CAT_EDGE,   // SO moves on falling SCK
        CAT_LEVEL   // SO moves on rising SCK
    } sfc_cat_e;

    localparam logic [7:0] OPC_RD_EDGE  = 8'h68;
    localparam logic [7:0] OPC_RD_LEVEL = 8'hE8;

endpackage

// File: rtl/sfc_sync.sv
module sfc_sync #(
    parameter int             WIDTH     = 3,
    parameter int             STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {STAGES{RESET_VAL}};
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/sfc_addr_ctr.sv
module sfc_addr_ctr #(
    parameter int PAGE_BITS  = 13,
    parameter int COL_BITS   = 10,
    parameter int PAGE_BYTES = 528,
    parameter int NUM_PAGES  = 8192
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [PAGE_BITS-1:0] load_page,
    input  logic [COL_BITS-1:0]  load_col,
    input  logic                 step,
    output logic [PAGE_BITS-1:0] page,
    output logic [COL_BITS-1:0]  col
);

    localparam logic [COL_BITS-1:0]  LAST_COL  = COL_BITS'(PAGE_BYTES - 1);
    localparam logic [PAGE_BITS-1:0] LAST_PAGE = PAGE_BITS'(NUM_PAGES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page <= '0;
            col  <= '0;
        end else if (load) begin
            page <= load_page;
            col  <= load_col;
        end else if (step) begin
            if (col >= LAST_COL) begin
                col  <= '0;
                page <= (page == LAST_PAGE) ? '0 : page + PAGE_BITS'(1);
            end else begin
                col  <= col + COL_BITS'(1);
            end
        end
    end

endmodule

// File: rtl/sfc_out_shift.sv
module sfc_out_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              edge_en,
    input  logic [DATA_W-1:0] din,
    output logic              so,
    output logic              live,
    output logic              taken
);

    localparam int LEFT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] sr;
    logic [LEFT_W-1:0] left;

    assign taken = edge_en && !clear && (left == '0);
    assign so    = sr[DATA_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            left <= '0;
            live <= 1'b0;
        end else if (clear) begin
            sr   <= '0;
            left <= '0;
            live <= 1'b0;
        end else if (edge_en) begin
            if (left == '0) begin
                sr   <= din;
                left <= LEFT_W'(DATA_W - 1);
                live <= 1'b1;
            end else begin
                sr   <= {sr[DATA_W-2:0], 1'b0};
                left <= left - LEFT_W'(1);
            end
        end
    end

endmodule

// File: rtl/sflash_cmd_frontend.sv
module sflash_cmd_frontend
    import sfc_pkg::*;
#(
    parameter int PAGE_BITS   = 13,
    parameter int COL_BITS    = 10,
    parameter int PAGE_BYTES  = 528,
    parameter int NUM_PAGES   = 8192,
    parameter int OPC_W       = 8,
    parameter int ADDR_PAD    = 1,
    parameter int DUMMY_CLKS  = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sck,
    input  logic                 si,
    output logic                 so,
    output logic                 so_oe,
    output logic                 mem_rd_en,
    output logic [PAGE_BITS-1:0] mem_page,
    output logic [COL_BITS-1:0]  mem_col,
    input  logic [7:0]           mem_rdata
);

    localparam int LOC_W   = PAGE_BITS + COL_BITS;
    localparam int ADDR_W  = ADDR_PAD + LOC_W;
    localparam int MAX_A   = (OPC_W > ADDR_W) ? OPC_W : ADDR_W;
    localparam int CNT_MAX = (MAX_A > DUMMY_CLKS) ? MAX_A : DUMMY_CLKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    // synchronised pins
    logic cs_s, sck_s, si_s, sck_prev;
    logic cs_low, sck_rise, sck_fall, shift_edge;

    sfc_sync #(
        .WIDTH    (3),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs_n, sck, si}),
        .q    ({cs_s, sck_s, si_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    assign cs_low   = !cs_s;
    assign sck_rise = cs_low && sck_s && !sck_prev;
    assign sck_fall = cs_low && !sck_s && sck_prev;

    // controller state
    sfc_state_e state_q, state_d;
    sfc_cat_e   cat_q;
    logic [CNT_W-1:0]   cnt;
    logic [OPC_W-2:0]   opc_sr;
    logic [LOC_W-2:0]   addr_sr;
    logic [OPC_W-1:0]   opc_full;
    logic [LOC_W-1:0]   loc_full;
    logic               fetch_q, rd_vld_q;
    logic [7:0]         hold;
    logic               ctr_load, edge_en, taken, live;

    assign opc_full   = {opc_sr, si_s};
    assign loc_full   = {addr_sr, si_s};
    assign shift_edge = (cat_q == CAT_LEVEL) ? sck_rise : sck_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!cs_low) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_OPCODE;
                ST_OPCODE: if (sck_rise && cnt == CNT_W'(OPC_W - 1))
                               state_d = (opc_full == OPC_RD_EDGE || opc_full == OPC_RD_LEVEL)
                                         ? ST_ADDR : ST_IGNORE;
                ST_ADDR:   if (sck_rise && cnt == CNT_W'(ADDR_W - 1))
                               state_d = ST_DUMMY;
                ST_DUMMY:  if (sck_rise && cnt == CNT_W'(DUMMY_CLKS - 1))
                               state_d = ST_STREAM;
                ST_STREAM: state_d = ST_STREAM;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            opc_sr   <= '0;
            addr_sr  <= '0;
            cat_q    <= CAT_EDGE;
            fetch_q  <= 1'b0;
            rd_vld_q <= 1'b0;
            hold     <= '0;
        end else begin
            fetch_q  <= taken;
            rd_vld_q <= mem_rd_en;
            if (rd_vld_q) hold <= mem_rdata;

            if (state_d != state_q) cnt <= '0;
            else if (sck_rise)      cnt <= cnt + CNT_W'(1);

            unique case (state_q)
                ST_OPCODE: begin
                    if (sck_rise) opc_sr <= opc_full[OPC_W-2:0];
                    if (state_d == ST_ADDR)
                        cat_q <= (opc_full == OPC_RD_LEVEL) ? CAT_LEVEL : CAT_EDGE;
                end
                ST_ADDR: begin
                    if (sck_rise) addr_sr <= loc_full[LOC_W-2:0];
                    if (state_d == ST_DUMMY) fetch_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ctr_load = (state_q == ST_ADDR) && (state_d == ST_DUMMY);
    assign edge_en  = ((state_q == ST_STREAM) && shift_edge) ||
                      ((state_q == ST_DUMMY) && (state_d == ST_STREAM) && (cat_q == CAT_LEVEL));

    sfc_addr_ctr #(
        .PAGE_BITS (PAGE_BITS),
        .COL_BITS  (COL_BITS),
        .PAGE_BYTES(PAGE_BYTES),
        .NUM_PAGES (NUM_PAGES)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_page(loc_full[COL_BITS +: PAGE_BITS]),
        .load_col (loc_full[COL_BITS-1:0]),
        .step     (fetch_q),
        .page     (mem_page),
        .col      (mem_col)
    );

    sfc_out_shift #(
        .DATA_W(8)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state_q == ST_IDLE),
        .edge_en(edge_en),
        .din    (hold),
        .so     (so),
        .live   (live),
        .taken  (taken)
    );

    assign mem_rd_en = fetch_q;
    assign so_oe     = live && (state_q == ST_STREAM);

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker
    import sfc_pkg::*;
#(
    parameter int PAGE_BITS   = 13,
    parameter int COL_BITS    = 10,
    parameter int PAGE_BYTES  = 528,
    parameter int NUM_PAGES   = 8192,
    parameter int SYNC_STAGES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_n,
    input logic                 so,
    input logic                 so_oe,
    input logic                 mem_rd_en,
    input logic [PAGE_BITS-1:0] mem_page,
    input logic [COL_BITS-1:0]  mem_col,
    input logic                 shift_edge,
    input sfc_state_e           state_q
);

    logic [3:0]           hi_cnt;
    logic                 has_prev;
    logic [PAGE_BITS-1:0] prev_page, exp_page;
    logic [COL_BITS-1:0]  prev_col, exp_col;
    logic                 prev_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt    <= '0;
            has_prev  <= 1'b0;
            prev_page <= '0;
            prev_col  <= '0;
        end else begin
            if (cs_n) hi_cnt <= (hi_cnt == 4'hF) ? hi_cnt : hi_cnt + 4'd1;
            else      hi_cnt <= '0;
            if (cs_n) begin
                has_prev <= 1'b0;
            end else if (mem_rd_en) begin
                has_prev  <= 1'b1;
                prev_page <= mem_page;
                prev_col  <= mem_col;
            end
        end
    end

    assign prev_last = (prev_col >= COL_BITS'(PAGE_BYTES - 1));
    assign exp_col   = prev_last ? '0 : prev_col + COL_BITS'(1);
    assign exp_page  = !prev_last ? prev_page :
                       (prev_page == PAGE_BITS'(NUM_PAGES - 1)) ? '0 : prev_page + PAGE_BITS'(1);

    AST_CS_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt >= 4'(SYNC_STAGES + 1)) |-> !so_oe);  // R1
    AST_IGNORE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !mem_rd_en);  // R3
    AST_SO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && !shift_edge) |=> (!so_oe || $stable(so)));  // R6 R7
    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && has_prev) |-> (mem_col == exp_col));  // R9
    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && has_prev) |-> (mem_page == exp_page));  // R10
    AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);  // R12

endmodule

bind sflash_cmd_frontend sfc_checker #(
    .PAGE_BITS  (PAGE_BITS),
    .COL_BITS   (COL_BITS),
    .PAGE_BYTES (PAGE_BYTES),
    .NUM_PAGES  (NUM_PAGES),
    .SYNC_STAGES(SYNC_STAGES)
) u_sfc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .so        (so),
    .so_oe     (so_oe),
    .mem_rd_en (mem_rd_en),
    .mem_page  (mem_page),
    .mem_col   (mem_col),
    .shift_edge(shift_edge),
    .state_q   (state_q)
);

// File: tb/sflash_cmd_frontend_bench.sv
`timescale 1ns/1ps
module sflash_cmd_frontend_bench;

    localparam int H    = 6;     // clk cycles per SCK phase
    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        si = 1'b0;
    logic        so, so_oe, mem_rd_en;
    logic [12:0] mem_page;
    logic [9:0]  mem_col;
    logic [7:0]  mem_rdata = '0;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    sflash_cmd_frontend u_sflash_cmd_frontend (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .si       (si),
        .so       (so),
        .so_oe    (so_oe),
        .mem_rd_en(mem_rd_en),
        .mem_page (mem_page),
        .mem_col  (mem_col),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] arr_byte(input int pg, input int cl);
        return 8'((pg * 37) ^ (cl * 11) ^ (pg >> 4) ^ 8'hA5);
    endfunction

    // behavioural array: answers one cycle after the request (R12)
    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= arr_byte(int'(mem_page), int'(mem_col));
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    task automatic bit_cycle(input logic b, output logic a_so, output logic a_oe,
                             output logic b_so, output logic b_oe);
        si = b;
        repeat (H) @(negedge clk);
        a_so = so; a_oe = so_oe;
        sck = 1'b1;
        repeat (H) @(negedge clk);
        b_so = so; b_oe = so_oe;
        sck = 1'b0;
    endtask

    task automatic run_frame(input logic [7:0] opc, input bit idle_hi, input int pg,
                             input int cl, input int nbytes, input int stop_at);
        logic [63:0] hdr;
        logic        a_so, a_oe, b_so, b_oe;
        logic [7:0]  rx [6];
        bit          valid, lvl, pre_bad;
        int          oe_bad, total, p, k;
        string       tag;
        valid   = (opc == 8'h68) || (opc == 8'hE8);
        lvl     = (opc == 8'hE8);
        pre_bad = 1'b0;
        oe_bad  = 0;
        foreach (rx[i]) rx[i] = '0;
        hdr   = {opc, 1'($urandom), 13'(pg), 10'(cl), 32'($urandom)};
        total = 64 + 8 * nbytes;
        sck = idle_hi;
        repeat (H) @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        sck = 1'b0;
        repeat (H) @(negedge clk);
        for (int c = 0; c < total; c++) begin
            if (stop_at >= 0 && c == stop_at) break;
            bit_cycle((c < 64) ? hdr[63-c] : 1'($urandom), a_so, a_oe, b_so, b_oe);
            if (!valid) begin
                if (a_oe || b_oe) oe_bad++;
            end else if (!lvl) begin
                if (c < 64) begin
                    if (a_oe || b_oe) pre_bad = 1'b1;
                end else begin
                    if (!a_oe) oe_bad++;
                    rx[(c-64)/8][7-((c-64)%8)] = a_so;
                end
            end else begin
                if (c <= 63 && a_oe) pre_bad = 1'b1;
                if (c < 63 && b_oe)  pre_bad = 1'b1;
                if (c >= 63 && (c - 63) < 8 * nbytes) begin
                    if (!b_oe) oe_bad++;
                    rx[(c-63)/8][7-((c-63)%8)] = b_so;
                end
            end
        end
        if (stop_at >= 0) begin
            // R11: cut the stream with SCK high
            sck = 1'b1;
            repeat (2) @(negedge clk);
            cs_n = 1'b1;
            repeat (SYNC + 3) @(negedge clk);
            check(!so_oe, "R11 abort", int'(so_oe), 0);
            sck = idle_hi;
            repeat (2 * H) @(negedge clk);
            return;
        end
        sck = idle_hi;
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (H) @(negedge clk);
        check(!so_oe, "R1 after frame", int'(so_oe), 0);
        if (!valid) begin
            check(oe_bad == 0, "R3 unknown opcode", oe_bad, 0);
            return;
        end
        check(!pre_bad, "R5 R2 preamble", int'(pre_bad), 0);
        check(oe_bad == 0, lvl ? "R7 data enable" : "R6 data enable", oe_bad, 0);
        p = pg; k = cl;
        tag = "R4";
        for (int b = 0; b < nbytes; b++) begin
            check(rx[b] == arr_byte(p, k),
                  $sformatf("%s %s R8 R12 byte%0d pg%0d col%0d", tag, lvl ? "R7" : "R6", b, p, k),
                  int'(rx[b]), int'(arr_byte(p, k)));
            tag = "R8";
            if (k >= 527) begin
                k = 0;
                if (p == 8191) begin p = 0; tag = "R10"; end
                else begin p = p + 1; tag = "R9"; end
            end else begin
                k = k + 1;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        check(!so_oe, "R1 reset enable", int'(so_oe), 0);
        check(!mem_rd_en, "R12 reset request", int'(mem_rd_en), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // directed corners
        run_frame(8'h68, 1'b0, 0, 0, 3, -1);
        run_frame(8'hE8, 1'b1, 100, 526, 4, -1);      // R9
        run_frame(8'h68, 1'b1, 8191, 525, 5, -1);     // R10
        run_frame(8'hE8, 1'b0, 8191, 527, 2, -1);     // R10
        run_frame(8'h0B, 1'b0, 7, 3, 2, -1);          // R3
        run_frame(8'h68, 1'b0, 5, 10, 4, 70);         // R11
        run_frame(8'hE8, 1'b1, 9, 20, 3, -1);
        run_frame(8'hE8, 1'b0, 12, 30, 4, 66);        // R11
        run_frame(8'h68, 1'b0, 4000, 1, 2, -1);

        // R1: SCK and SI activity while CS is high
        for (int t = 0; t < 12; t++) begin
            si  = 1'($urandom);
            sck = ~sck;
            repeat (H) @(negedge clk);
            check(!so_oe, "R1 idle toggling", int'(so_oe), 0);
        end
        sck = 1'b0;
        run_frame(8'hE8, 1'b0, 321, 400, 2, -1);

        // random frames
        for (int n = 0; n < 26; n++) begin
            logic [7:0] opc;
            int pg, cl, nb, stop;
            int sel;
            sel = int'($urandom % 10);
            if (sel < 4)      opc = 8'h68;
            else if (sel < 8) opc = 8'hE8;
            else begin
                opc = 8'($urandom);
                if (opc == 8'h68 || opc == 8'hE8) opc = 8'h00;
            end
            pg = ($urandom % 4 == 0) ? 8191 : int'($urandom % 8192);
            cl = ($urandom % 2 == 0) ? 520 + int'($urandom % 8) : int'($urandom % 528);
            nb = 1 + int'($urandom % 6);
            stop = ($urandom % 6 == 0) ? 64 + int'($urandom % (8 * nb)) : -1;
            run_frame(opc, 1'($urandom), pg, cl, nb, stop);
        end

        done = 1'b1;
        report();
    end

endmodule